// File: doc/BRIEF.md
# Machine Check Error Logger

This block gathers error events from the cache and bus units of a processor core and records each one in a sticky syndrome register, one bit per error class. Some classes also capture the failing data address, the failing instruction address, or both. A machine-check request stays raised while any syndrome bit is set. Two suppression strobes act in the same cycle as the error: one stops a returned line from being written into the first-level cache, and the other stops the failing instruction from executing.

Error sources fall into two groups:
- **Write-back errors.** These arise while a line is pushed out of the data cache by a castout or a snoop. They are an address-bus error, a write-data error signalled on an active-low input, and a parity error in the pushed data.
- **Fetch errors.** These arise on the instruction side. They are a parity error on a cache hit, and an address-bus, read-data or read-parity error on a fetch miss.

Software reads the syndrome and address outputs. It clears syndrome bits, and the valid flag of the data address, through a write-one-to-clear port.

Top module: `mc_err_logger`

## Requirements
- R1: After reset the syndrome is zero, the data address, its valid flag and the saved instruction address are zero, and the machine-check request is low.
- R2: An event pulse sets its syndrome bit one cycle later, at these positions: bit 0 push address error, bit 1 write-data error, bit 2 push parity error, bit 3 fetch-hit parity error, bit 4 fetch-miss address error, bit 5 fetch-miss read-data error, bit 6 fetch-miss read-parity error. The write-data error input is active low.
- R3: Syndrome bits are sticky. A write with clear-enable high clears each syndrome bit whose data bit (bits 6..0) is 1. An event arriving in the same cycle as the clear of its own bit leaves that bit set.
- R4: The machine-check request is high exactly when at least one syndrome bit is set.
- R5: A push address error loads the data address from the push address when no address is held. It never changes the saved instruction address.
- R6: A write-data error or a push parity error sets only its syndrome bit. The data address, its valid flag and the saved instruction address are left unchanged.
- R7: A fetch-hit parity error loads the saved instruction address from the fetch PC, leaves the data address unchanged, and raises suppress-execute in the same cycle.
- R8: Each fetch-miss error loads the saved instruction address from the fetch PC and loads the data address from the fetch address when none is held. It raises suppress-fill and suppress-execute in the same cycle.
- R9: A held data address keeps its first value until a clear write with data bit 7 set drops its valid flag. A clear and a new address-carrying event in the same cycle capture the new address and leave the flag set.
- R10: Events in the same cycle all set their bits together. For the data address, a fetch-miss error takes priority over a push address error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_addr_err_i | input | 1 | Address-bus error on castout or snoop push |
| push_addr_i | input | ADDR_W | Address on the line being pushed |
| push_wr_err_ni | input | 1 | Write-data bus error, active low |
| push_par_err_i | input | 1 | Parity error in data being pushed |
| fetch_pc_i | input | PC_W | Address of the instruction being fetched |
| fetch_hit_par_err_i | input | 1 | Instruction cache parity error on a hit |
| fetch_miss_addr_err_i | input | 1 | Address-bus error on a fetch miss |
| fetch_miss_rdata_err_i | input | 1 | Read-data bus error on a fetch miss |
| fetch_miss_rpar_err_i | input | 1 | Read-data parity error on a fetch miss |
| fetch_addr_i | input | ADDR_W | Line address of the fetch miss |
| sw_clr_we_i | input | 1 | Software clear strobe |
| sw_clr_data_i | input | 8 | Clear mask: bits 6..0 syndrome, bit 7 data address valid |
| syndrome_o | output | 7 | Sticky syndrome register |
| dar_o | output | ADDR_W | Captured data address |
| dar_vld_o | output | 1 | Data address valid |
| sia_o | output | PC_W | Saved instruction address |
| mc_req_o | output | 1 | Machine-check request |
| suppress_fill_o | output | 1 | Block the returned line from the cache |
| suppress_exec_o | output | 1 | Block execution of the failing instruction |

## Verification
The syndrome, the request, both address registers and the valid flag are registered, so they change at the first rising edge after the event or clear. The two suppression strobes are combinational and are valid in the same cycle as the event. The bench drives inputs just after a falling edge. Its reference model updates on the rising edge from the inputs it sees there. Registered outputs are compared with the model at every falling edge, and the strobes are checked at the rising edge against the inputs held during that cycle.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
    localparam int NUM_ERR = 7;
    localparam int CLR_W   = NUM_ERR + 1;

    // syndrome bit positions
    localparam int SB_PUSH_ADDR  = 0;
    localparam int SB_PUSH_WDATA = 1;
    localparam int SB_PUSH_PAR   = 2;
    localparam int SB_HIT_PAR    = 3;
    localparam int SB_MISS_ADDR  = 4;
    localparam int SB_MISS_RDATA = 5;
    localparam int SB_MISS_RPAR  = 6;
    localparam int CB_DAR_VLD    = NUM_ERR;

    typedef logic [NUM_ERR-1:0] syn_t;
endpackage

// File: rtl/mcl_event_decode.sv
module mcl_event_decode
    import mcl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              push_addr_err_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              push_wr_err_ni,
    input  logic              push_par_err_i,
    input  logic              hit_par_err_i,
    input  logic              miss_addr_err_i,
    input  logic              miss_rdata_err_i,
    input  logic              miss_rpar_err_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    output syn_t              ev_vec_o,
    output logic              dar_load_o,
    output logic [ADDR_W-1:0] dar_src_o,
    output logic              sia_load_o,
    output logic              sup_fill_o,
    output logic              sup_exec_o
);
    logic miss_any;

    always_comb begin
        ev_vec_o                = '0;
        ev_vec_o[SB_PUSH_ADDR]  = push_addr_err_i;
        ev_vec_o[SB_PUSH_WDATA] = ~push_wr_err_ni;
        ev_vec_o[SB_PUSH_PAR]   = push_par_err_i;
        ev_vec_o[SB_HIT_PAR]    = hit_par_err_i;
        ev_vec_o[SB_MISS_ADDR]  = miss_addr_err_i;
        ev_vec_o[SB_MISS_RDATA] = miss_rdata_err_i;
        ev_vec_o[SB_MISS_RPAR]  = miss_rpar_err_i;

        miss_any   = miss_addr_err_i | miss_rdata_err_i | miss_rpar_err_i;
        // fetch-miss address outranks push address
        dar_load_o = miss_any | push_addr_err_i;
        dar_src_o  = miss_any ? fetch_addr_i : push_addr_i;
        sia_load_o = miss_any | hit_par_err_i;
        sup_fill_o = miss_any;
        sup_exec_o = miss_any | hit_par_err_i;
    end
endmodule

// File: rtl/mcl_syndrome.sv
module mcl_syndrome
    import mcl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  syn_t ev_vec_i,
    input  logic clr_we_i,
    input  syn_t clr_mask_i,
    output syn_t syn_o
);
    typedef struct packed {
        syn_t syn;
    } syn_state_t;

    syn_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we_i) begin
            st_d.syn = st_d.syn & ~clr_mask_i;
        end
        // a new event wins over a clear of the same bit
        st_d.syn = st_d.syn | ev_vec_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign syn_o = st_q.syn;
endmodule

// File: rtl/mcl_capture.sv
module mcl_capture #(
    parameter int ADDR_W = 32,
    parameter int PC_W   = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              dar_load_i,
    input  logic [ADDR_W-1:0] dar_src_i,
    input  logic              dar_clr_i,
    input  logic              sia_load_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic [ADDR_W-1:0] dar_o,
    output logic              dar_vld_o,
    output logic [PC_W-1:0]   sia_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] dar;
        logic              dar_vld;
        logic [PC_W-1:0]   sia;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       held;

    always_comb begin
        st_d = st_q;
        held = st_q.dar_vld & ~dar_clr_i;
        st_d.dar_vld = held;
        if (!held && dar_load_i) begin
            st_d.dar     = dar_src_i;
            st_d.dar_vld = 1'b1;
        end
        if (sia_load_i) begin
            st_d.sia = pc_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dar_o     = st_q.dar;
    assign dar_vld_o = st_q.dar_vld;
    assign sia_o     = st_q.sia;
endmodule

// File: rtl/mc_err_logger.sv
module mc_err_logger
    import mcl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PC_W   = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                push_addr_err_i,
    input  logic [ADDR_W-1:0]   push_addr_i,
    input  logic                push_wr_err_ni,
    input  logic                push_par_err_i,
    input  logic [PC_W-1:0]     fetch_pc_i,
    input  logic                fetch_hit_par_err_i,
    input  logic                fetch_miss_addr_err_i,
    input  logic                fetch_miss_rdata_err_i,
    input  logic                fetch_miss_rpar_err_i,
    input  logic [ADDR_W-1:0]   fetch_addr_i,
    input  logic                sw_clr_we_i,
    input  logic [CLR_W-1:0]    sw_clr_data_i,
    output logic [NUM_ERR-1:0]  syndrome_o,
    output logic [ADDR_W-1:0]   dar_o,
    output logic                dar_vld_o,
    output logic [PC_W-1:0]     sia_o,
    output logic                mc_req_o,
    output logic                suppress_fill_o,
    output logic                suppress_exec_o
);
    syn_t              ev_vec;
    logic              dar_load;
    logic [ADDR_W-1:0] dar_src;
    logic              sia_load;
    logic              dar_clr;

    assign dar_clr = sw_clr_we_i & sw_clr_data_i[CB_DAR_VLD];

    mcl_event_decode #(.ADDR_W(ADDR_W)) i_decode (
        .push_addr_err_i  (push_addr_err_i),
        .push_addr_i      (push_addr_i),
        .push_wr_err_ni   (push_wr_err_ni),
        .push_par_err_i   (push_par_err_i),
        .hit_par_err_i    (fetch_hit_par_err_i),
        .miss_addr_err_i  (fetch_miss_addr_err_i),
        .miss_rdata_err_i (fetch_miss_rdata_err_i),
        .miss_rpar_err_i  (fetch_miss_rpar_err_i),
        .fetch_addr_i     (fetch_addr_i),
        .ev_vec_o         (ev_vec),
        .dar_load_o       (dar_load),
        .dar_src_o        (dar_src),
        .sia_load_o       (sia_load),
        .sup_fill_o       (suppress_fill_o),
        .sup_exec_o       (suppress_exec_o)
    );

    mcl_syndrome i_syndrome (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ev_vec_i   (ev_vec),
        .clr_we_i   (sw_clr_we_i),
        .clr_mask_i (sw_clr_data_i[NUM_ERR-1:0]),
        .syn_o      (syndrome_o)
    );

    mcl_capture #(.ADDR_W(ADDR_W), .PC_W(PC_W)) i_capture (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .dar_load_i (dar_load),
        .dar_src_i  (dar_src),
        .dar_clr_i  (dar_clr),
        .sia_load_i (sia_load),
        .pc_i       (fetch_pc_i),
        .dar_o      (dar_o),
        .dar_vld_o  (dar_vld_o),
        .sia_o      (sia_o)
    );

    assign mc_req_o = |syndrome_o;
endmodule

// File: rtl/mcl_checker.sv
module mcl_checker
    import mcl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PC_W   = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input syn_t               ev_vec,
    input logic               hit_err,
    input logic               miss_err,
    input logic               sw_clr_we_i,
    input logic [CLR_W-1:0]   sw_clr_data_i,
    input syn_t               syndrome_o,
    input logic [ADDR_W-1:0]  dar_o,
    input logic               dar_vld_o,
    input logic [PC_W-1:0]    sia_o,
    input logic               mc_req_o,
    input logic               suppress_fill_o,
    input logic               suppress_exec_o
);
    syn_t clr_mask;
    logic dar_clr;

    assign clr_mask = sw_clr_we_i ? sw_clr_data_i[NUM_ERR-1:0] : '0;
    assign dar_clr  = sw_clr_we_i & sw_clr_data_i[CB_DAR_VLD];

    a_r2_event_sets_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((syndrome_o & $past(ev_vec)) == $past(ev_vec)));

    a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(syndrome_o) & ~$past(clr_mask) & ~syndrome_o) == '0));

    a_r4_req_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (syndrome_o != '0) |-> mc_req_o);

    a_r4_req_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mc_req_o) |-> ($past(ev_vec) != '0));

    a_r9_dar_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dar_vld_o && !dar_clr) |=> (dar_vld_o && $stable(dar_o)));

    a_r8_fill_implies_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
        suppress_fill_o |-> suppress_exec_o);

    a_r5_sia_fetch_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hit_err || miss_err) |=> $stable(sia_o));
endmodule

bind mc_err_logger mcl_checker #(.ADDR_W(ADDR_W), .PC_W(PC_W)) i_mcl_checker (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .ev_vec          (ev_vec),
    .hit_err         (fetch_hit_par_err_i),
    .miss_err        (fetch_miss_addr_err_i | fetch_miss_rdata_err_i | fetch_miss_rpar_err_i),
    .sw_clr_we_i     (sw_clr_we_i),
    .sw_clr_data_i   (sw_clr_data_i),
    .syndrome_o      (syndrome_o),
    .dar_o           (dar_o),
    .dar_vld_o       (dar_vld_o),
    .sia_o           (sia_o),
    .mc_req_o        (mc_req_o),
    .suppress_fill_o (suppress_fill_o),
    .suppress_exec_o (suppress_exec_o)
);

// File: tb/test_mc_err_logger.sv
`timescale 1ns/1ps
module test_mc_err_logger;
    localparam int AW = 32;
    localparam int PW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          paddr_err = 0, pwr_n = 1, ppar_err = 0;
    logic [AW-1:0] paddr = '0;
    logic [PW-1:0] pc = '0;
    logic          hit_par = 0, m_addr = 0, m_rdata = 0, m_rpar = 0;
    logic [AW-1:0] faddr = '0;
    logic          clr_we = 0;
    logic [7:0]    clr_data = '0;
    logic [6:0]    syn;
    logic [AW-1:0] dar;
    logic          dvld;
    logic [PW-1:0] sia;
    logic          req, sfill, sexec;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mc_err_logger #(.ADDR_W(AW), .PC_W(PW)) i_mc_err_logger (
        .clk_i(clk), .rst_ni(rst_n),
        .push_addr_err_i(paddr_err), .push_addr_i(paddr),
        .push_wr_err_ni(pwr_n), .push_par_err_i(ppar_err),
        .fetch_pc_i(pc), .fetch_hit_par_err_i(hit_par),
        .fetch_miss_addr_err_i(m_addr), .fetch_miss_rdata_err_i(m_rdata),
        .fetch_miss_rpar_err_i(m_rpar), .fetch_addr_i(faddr),
        .sw_clr_we_i(clr_we), .sw_clr_data_i(clr_data),
        .syndrome_o(syn), .dar_o(dar), .dar_vld_o(dvld), .sia_o(sia),
        .mc_req_o(req), .suppress_fill_o(sfill), .suppress_exec_o(sexec)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model
    logic [6:0]    r_syn  = '0;
    logic [AW-1:0] r_dar  = '0;
    logic          r_dvld = 0;
    logic [PW-1:0] r_sia  = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_syn = '0; r_dar = '0; r_dvld = 0; r_sia = '0;
        end else begin
            logic [6:0] ev;
            logic       miss;
            miss = m_addr | m_rdata | m_rpar;
            // same-cycle strobes (R8, R7)
            chk("R8 suppress_fill", {63'b0, sfill}, {63'b0, miss});
            chk("R7 suppress_exec", {63'b0, sexec}, {63'b0, miss | hit_par});
            ev = {m_rpar, m_rdata, m_addr, hit_par, ppar_err, ~pwr_n, paddr_err};
            if (clr_we) r_syn = r_syn & ~clr_data[6:0];
            r_syn = r_syn | ev;
            if (clr_we && clr_data[7]) r_dvld = 0;
            if (!r_dvld) begin
                if (miss) begin r_dar = faddr; r_dvld = 1; end
                else if (paddr_err) begin r_dar = paddr; r_dvld = 1; end
            end
            if (miss || hit_par) r_sia = pc;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 syndrome", {57'b0, syn}, {57'b0, r_syn});
            chk("R4 mc_req", {63'b0, req}, {63'b0, |r_syn});
            chk("R9 dar", {32'b0, dar}, {32'b0, r_dar});
            chk("R9 dar_vld", {63'b0, dvld}, {63'b0, r_dvld});
            chk("R7 sia", {32'b0, sia}, {32'b0, r_sia});
        end
    end

    task automatic idle();
        paddr_err = 0; pwr_n = 1; ppar_err = 0; hit_par = 0;
        m_addr = 0; m_rdata = 0; m_rpar = 0; clr_we = 0; clr_data = '0;
    endtask

    // hold the current stimulus for one cycle, then go idle; outputs are updated on return
    task automatic fire();
        @(negedge clk);
        idle();
    endtask

    task automatic clear(input logic [7:0] m);
        @(negedge clk);
        clr_we = 1; clr_data = m;
        fire();
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        chk("R1 reset syndrome", {57'b0, syn}, 64'd0);
        chk("R1 reset dar_vld", {63'b0, dvld}, 64'd0);
        chk("R1 reset mc_req", {63'b0, req}, 64'd0);
        chk("R1 reset sia", {32'b0, sia}, 64'd0);
        rst_n = 1;
        @(negedge clk);

        // push address error
        pc = 32'h1000; paddr = 32'hA000_0040; paddr_err = 1;
        fire();
        chk("R5 push addr bit0", {57'b0, syn}, 64'h01);
        chk("R5 dar from push", {32'b0, dar}, 64'hA000_0040);
        chk("R5 sia untouched", {32'b0, sia}, 64'd0);
        clear(8'h81);
        chk("R3 cleared", {57'b0, syn}, 64'd0);
        chk("R9 valid cleared", {63'b0, dvld}, 64'd0);

        // write-data (active low) and push parity
        @(negedge clk); pwr_n = 0; paddr = 32'hB000_0000;
        fire();
        @(negedge clk); ppar_err = 1;
        fire();
        chk("R6 bits 1 and 2", {57'b0, syn}, 64'h06);
        chk("R6 dar_vld unchanged", {63'b0, dvld}, 64'd0);
        chk("R6 sia unchanged", {32'b0, sia}, 64'd0);
        clear(8'h7F);

        // fetch-hit parity
        @(negedge clk); pc = 32'h0000_2468; hit_par = 1;
        fire();
        chk("R7 bit3", {57'b0, syn}, 64'h08);
        chk("R7 sia loaded", {32'b0, sia}, 64'h2468);
        chk("R7 dar not loaded", {63'b0, dvld}, 64'd0);

        // fetch-miss address error
        @(negedge clk); pc = 32'h0000_3000; faddr = 32'hC000_3000; m_addr = 1;
        fire();
        chk("R8 bit4 set", {57'b0, syn}, 64'h18);
        chk("R8 dar loaded", {32'b0, dar}, 64'hC000_3000);
        chk("R8 sia loaded", {32'b0, sia}, 64'h3000);

        // later push address error: address held
        @(negedge clk); paddr_err = 1; paddr = 32'hD000_0000;
        fire();
        chk("R9 dar held", {32'b0, dar}, 64'hC000_3000);
        chk("R9 bit0 still set", {57'b0, syn & 7'h01}, 64'h01);

        // clear valid and new read-data miss in same cycle
        @(negedge clk); clr_we = 1; clr_data = 8'h80; m_rdata = 1; faddr = 32'hE000_0100; pc = 32'h4000;
        fire();
        chk("R9 recapture on clear", {32'b0, dar}, 64'hE000_0100);
        chk("R9 valid kept", {63'b0, dvld}, 64'd1);
        clear(8'hFF);

        // read parity miss alone
        @(negedge clk); m_rpar = 1; faddr = 32'hF000_0000; pc = 32'h5000;
        fire();
        chk("R2 bit6", {57'b0, syn}, 64'h40);
        clear(8'hFF);

        // priority: push and miss in same cycle
        @(negedge clk); paddr_err = 1; paddr = 32'h1111_0000; m_rdata = 1; faddr = 32'h2222_0000;
        hit_par = 1; pc = 32'h6000;
        fire();
        chk("R10 all bits", {57'b0, syn}, 64'h29);
        chk("R10 fetch addr wins", {32'b0, dar}, 64'h2222_0000);

        // set and clear same bit
        @(negedge clk); clr_we = 1; clr_data = 8'h21; m_rdata = 1;
        fire();
        chk("R3 set beats clear", {57'b0, syn}, 64'h28);
        clear(8'hFF);
        chk("R4 req low after clear", {63'b0, req}, 64'd0);

        // mixed pattern run
        for (int i = 0; i < 300; i++) begin
            logic [31:0] v;
            @(negedge clk);
            v = $urandom;
            paddr_err = (v[2:0] == 0); pwr_n = (v[5:3] != 0); ppar_err = (v[8:6] == 0);
            hit_par = (v[11:9] == 0); m_addr = (v[14:12] == 0); m_rdata = (v[17:15] == 0);
            m_rpar = (v[20:18] == 0); clr_we = (v[23:21] == 0); clr_data = $urandom;
            paddr = $urandom; faddr = $urandom; pc = $urandom;
        end
        @(negedge clk); idle();
        repeat (2) @(negedge clk);

        finished = 1;
        summary();
        $finish;
    end
endmodule